// File: doc/BRIEF.md
# Quad SPI Slave Word Streamer

This block lets an external SPI master read a local memory of 32-bit words. The master pulls chip select low and shifts in a four-byte header on D0. The first three bytes are a word address and the last byte is a command. The block then sends words from that address and from each following address, with no gap between words. It keeps going for as long as chip select stays low. The command selects the data width: one bit per SCLK cycle on D1, or one nibble per SCLK cycle on all four data lines.

The block runs on a local clock that is much faster than SCLK. It samples SCLK and chip select as ordinary synchronous inputs and acts on the SCLK edges it detects. Each data line has a separate input, output and output enable. D0 is the only line the block ever reads. On the memory side, a read request returns its word one local clock later. The block fetches each next word while the current word is being shifted out, so the memory latency never shows on the wire. Raising chip select at any point abandons the transfer.

Top module: `qspi_stream_slave`

## Requirements
- R1: While chip select is low, the block samples D0 on each SCLK rising edge. The first 24 bits form the address and the next 8 bits form the command, each most significant bit first. No output enable is active during these 32 cycles.
- R2: Data outputs change only after an SCLK falling edge. In the single-line mode, bit 31 of the first word is valid at the first SCLK rising edge after the command's last bit.
- R3: Command 0x0B selects the single-line mode. Each word goes out on D1, bit 31 first, one bit per SCLK cycle, and the output enable pattern is 4'b0010 (only D1 enabled).
- R4: Command 0x6B selects the quad mode. The SCLK cycle right after the command is a turnaround cycle with all outputs disabled. From the next cycle on, each word goes out as 8 nibbles, most significant nibble first, with nibble bit 3 on D3 and bit 0 on D0, and the output enable pattern is 4'b1111.
- R5: After any other command value, every output enable stays low until chip select rises.
- R6: Out of reset, and whenever chip select is high, every output enable is low and no memory read is requested. When chip select rises in the middle of a header or data phase, the transfer is abandoned. The next low period starts with a new header.
- R7: Words follow one another with no idle SCLK cycle between them. Each word comes from the address one higher than the previous word. Only the low AW bits of the header address are used, and the address wraps from 2^AW-1 to 0. Once driving has begun, the output enable pattern holds until chip select rises.
- R8: The block issues one memory read when the header completes and one more at the start of each word, which prefetches the next address. It never asserts the read request in two consecutive local clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; SCLK and chip select are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| csN | input | 1 | Active-low chip select |
| d0In | input | 1 | Serial input on data line D0 |
| dOut | output | 4 | Output values for data lines D3..D0 |
| dOe | output | 4 | Output enables for data lines D3..D0 |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | AW | Word address of the memory read |
| memRdData | input | 32 | Read word, valid one clock after the request |

## Verification
The assertions assume that each SCLK high phase and each low phase lasts at least two local clock cycles, so that every SCLK edge is seen exactly once. They also assume that D0 and chip select change only while SCLK is low, and that the memory returns its word on the cycle after the request. The bench keeps within these limits. It holds each SCLK phase for four local clocks, drives D0 and chip select only during the low phase, and models the memory as a one-cycle registered lookup. That lookup computes a distinct value for every address. A master-side model in the bench rebuilds each word from the sampled lines and compares it with that lookup. A per-clock monitor checks that no line is driven while chip select is high.

// File: rtl/qspi_stream_pkg.sv
package qspi_stream_pkg;
  localparam int HDR_BITS  = 32;
  localparam int WORD_BITS = 32;
  localparam int HDR_CNT_W = $clog2(HDR_BITS);
  localparam int STEP_W    = $clog2(WORD_BITS);

  typedef enum logic [1:0] {
    ST_HDR,
    ST_TURN,
    ST_STREAM,
    ST_MUTE
  } phase_t;

  typedef struct packed {
    logic hdrShift;
    logic hdrDone;
    logic wordLoad;
    logic wordShift;
    logic quad;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/qspi_stream_ctrl.sv
module qspi_stream_ctrl
  import qspi_stream_pkg::*;
#(
  parameter logic [7:0] CMD_SINGLE = 8'h0B,
  parameter logic [7:0] CMD_QUAD   = 8'h6B
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       d0In,
  input  logic [6:0] cmdHead,
  output strobe_t    stb
);
  localparam logic [HDR_CNT_W-1:0] LAST_HDR    = HDR_CNT_W'(HDR_BITS - 1);
  localparam logic [STEP_W-1:0]    SINGLE_LAST = STEP_W'(WORD_BITS - 1);
  localparam logic [STEP_W-1:0]    QUAD_LAST   = STEP_W'(WORD_BITS / 4 - 1);

  phase_t               phaseQ;
  logic                 sclkQ;
  logic [HDR_CNT_W-1:0] bitCntQ;
  logic [STEP_W-1:0]    stepCntQ;
  logic                 quadQ;
  logic                 driveQ;

  logic       sclkRise;
  logic       sclkFall;
  logic       hdrLast;
  logic [7:0] cmdByte;
  logic       cmdSingle;
  logic       cmdQuad;

  assign sclkRise  = sclk & ~sclkQ;
  assign sclkFall  = ~sclk & sclkQ;
  assign hdrLast   = (bitCntQ == LAST_HDR);
  assign cmdByte   = {cmdHead, d0In};
  assign cmdSingle = (cmdByte == CMD_SINGLE);
  assign cmdQuad   = (cmdByte == CMD_QUAD);

  always_comb begin
    stb           = '0;
    stb.quad      = quadQ;
    stb.drive     = driveQ;
    if (!csN) begin
      stb.hdrShift  = (phaseQ == ST_HDR) && sclkRise;
      stb.hdrDone   = (phaseQ == ST_HDR) && sclkRise && hdrLast && (cmdSingle || cmdQuad);
      stb.wordLoad  = (phaseQ == ST_STREAM) && sclkFall && (stepCntQ == '0);
      stb.wordShift = (phaseQ == ST_STREAM) && sclkFall && (stepCntQ != '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
    end else begin
      sclkQ <= sclk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= ST_HDR;
      bitCntQ  <= '0;
      stepCntQ <= '0;
      quadQ    <= 1'b0;
      driveQ   <= 1'b0;
    end else if (csN) begin
      phaseQ   <= ST_HDR;
      bitCntQ  <= '0;
      stepCntQ <= '0;
      quadQ    <= 1'b0;
      driveQ   <= 1'b0;
    end else begin
      unique case (phaseQ)
        ST_HDR: begin
          if (sclkRise) begin
            if (hdrLast) begin
              quadQ    <= cmdQuad;
              stepCntQ <= '0;
              if (cmdSingle)    phaseQ <= ST_STREAM;
              else if (cmdQuad) phaseQ <= ST_TURN;
              else              phaseQ <= ST_MUTE;
            end else begin
              bitCntQ <= bitCntQ + 1'b1;
            end
          end
        end
        ST_TURN: begin
          if (sclkFall) phaseQ <= ST_STREAM;
        end
        ST_STREAM: begin
          if (sclkFall) begin
            if (stepCntQ == '0) begin
              stepCntQ <= quadQ ? QUAD_LAST : SINGLE_LAST;
              driveQ   <= 1'b1;
            end else begin
              stepCntQ <= stepCntQ - 1'b1;
            end
          end
        end
        default: begin
          phaseQ <= ST_MUTE;
        end
      endcase
    end
  end
endmodule

// File: rtl/qspi_stream_dp.sv
module qspi_stream_dp
  import qspi_stream_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 d0In,
  input  strobe_t              stb,
  output logic [6:0]           cmdHead,
  output logic                 memRdEn,
  output logic [AW-1:0]        memAddr,
  input  logic [WORD_BITS-1:0] memRdData,
  output logic [3:0]           dOut,
  output logic [3:0]           dOe
);
  localparam int            HW      = AW + 7;
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  logic [HW-1:0]        hdrQ;
  logic [AW-1:0]        addrQ;
  logic                 rdPendQ;
  logic [WORD_BITS-1:0] preQ;
  logic [WORD_BITS-1:0] txQ;

  assign cmdHead = hdrQ[6:0];
  assign memRdEn = stb.hdrDone | stb.wordLoad;
  assign memAddr = stb.hdrDone ? hdrQ[HW-1:7] : addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrQ    <= '0;
      addrQ   <= '0;
      rdPendQ <= 1'b0;
      preQ    <= '0;
      txQ     <= '0;
    end else begin
      if (stb.hdrShift) hdrQ <= {hdrQ[HW-2:0], d0In};
      if (memRdEn)      addrQ <= memAddr + ADDR_ONE;
      rdPendQ <= memRdEn;
      if (rdPendQ)      preQ <= memRdData;
      if (stb.wordLoad) begin
        txQ <= preQ;
      end else if (stb.wordShift) begin
        if (stb.quad) txQ <= {txQ[WORD_BITS-5:0], 4'b0000};
        else          txQ <= {txQ[WORD_BITS-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    if (stb.quad) begin
      dOut = txQ[WORD_BITS-1 -: 4];
      dOe  = stb.drive ? 4'b1111 : 4'b0000;
    end else begin
      dOut = {2'b00, txQ[WORD_BITS-1], 1'b0};
      dOe  = stb.drive ? 4'b0010 : 4'b0000;
    end
  end
endmodule

// File: rtl/qspi_stream_slave.sv
module qspi_stream_slave
  import qspi_stream_pkg::*;
#(
  parameter int         AW         = 8,
  parameter logic [7:0] CMD_SINGLE = 8'h0B,
  parameter logic [7:0] CMD_QUAD   = 8'h6B
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclk,
  input  logic          csN,
  input  logic          d0In,
  output logic [3:0]    dOut,
  output logic [3:0]    dOe,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [31:0]   memRdData
);
  strobe_t    stb;
  logic [6:0] cmdHead;
  logic [3:0] coreOe;

  qspi_stream_ctrl #(
    .CMD_SINGLE(CMD_SINGLE),
    .CMD_QUAD  (CMD_QUAD)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .csN    (csN),
    .d0In   (d0In),
    .cmdHead(cmdHead),
    .stb    (stb)
  );

  qspi_stream_dp #(
    .AW(AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .d0In     (d0In),
    .stb      (stb),
    .cmdHead  (cmdHead),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .memRdData(memRdData),
    .dOut     (dOut),
    .dOe      (coreOe)
  );

  assign dOe = csN ? 4'b0000 : coreOe;
endmodule

// File: rtl/qspi_stream_chk.sv
module qspi_stream_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclk,
  input logic          csN,
  input logic [3:0]    dOut,
  input logic [3:0]    dOe,
  input logic          memRdEn,
  input logic [AW-1:0] memAddr
);
  AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (dOe == 4'b0000)); // R6

  AST_OE_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (dOe == 4'b0000) || (dOe == 4'b0010) || (dOe == 4'b1111)); // R4

  AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && ($past(dOe) != 4'b0000)) |-> (dOe == $past(dOe))); // R7

  AST_DATA_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && (dOe != 4'b0000) && (dOut != $past(dOut))) |-> (!$past(sclk) && $past(sclk, 2))); // R2

  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R8

  AST_NO_READ_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !memRdEn); // R6

  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !$isunknown(memAddr)); // R8
endmodule

bind qspi_stream_slave qspi_stream_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclk   (sclk),
  .csN    (csN),
  .dOut   (dOut),
  .dOe    (dOe),
  .memRdEn(memRdEn),
  .memAddr(memAddr)
);

// File: tb/sim_qspi_stream_slave.sv
`timescale 1ns/1ps
module sim_qspi_stream_slave;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sclk = 1'b0;
  logic          csN = 1'b1;
  logic          d0In = 1'b0;
  logic [3:0]    dOut;
  logic [3:0]    dOe;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [31:0]   memRdData = '0;

  int checks = 0;
  int fails  = 0;
  int rdCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  qspi_stream_slave #(.AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .d0In(d0In),
    .dOut(dOut), .dOe(dOe), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData)
  );

  function automatic logic [31:0] memVal(input int a);
    logic [31:0] x;
    x = a;
    return (x * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memVal(int'(memAddr));
      rdCount   <= rdCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R6: per-clock monitor of the deselected state
  always @(negedge clk) begin
    if (rstN && csN) check(dOe == 4'b0000, "R6", "drive while deselected", {28'b0, dOe}, 32'h0);
  end

  task automatic sclkCycle(input logic d0, output logic [3:0] dv, output logic [3:0] ov);
    d0In = d0;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    dv = dOut;
    ov = dOe;
    sclk = 1'b0;
  endtask

  task automatic selectDev();
    @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselectDev();
    @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendHeader(input logic [23:0] addr, input logic [7:0] cmd);
    logic [31:0] hdr;
    logic [3:0]  dv;
    logic [3:0]  ov;
    logic [3:0]  oeSeen;
    hdr = {addr, cmd};
    oeSeen = '0;
    for (int i = 31; i >= 0; i--) begin
      sclkCycle(hdr[i], dv, ov);
      oeSeen |= ov;
    end
    check(oeSeen == 4'b0000, "R1", "output enable during header", {28'b0, oeSeen}, 32'h0);
  endtask

  task automatic recvSingle(input int n, input int startAddr);
    logic [3:0]  dv;
    logic [3:0]  ov;
    logic [31:0] word;
    bit          oeOk;
    for (int w = 0; w < n; w++) begin
      word = '0;
      oeOk = 1'b1;
      for (int b = 0; b < 32; b++) begin
        sclkCycle(1'b0, dv, ov);
        word = {word[30:0], dv[1]};
        if (ov != 4'b0010) oeOk = 1'b0;
      end
      check(word == memVal((startAddr + w) % DEPTH), (w == 0) ? "R2" : "R7",
            "single-line word", word, memVal((startAddr + w) % DEPTH));
      check(oeOk, "R3", "single-line enable pattern", {31'b0, oeOk}, 32'h1);
    end
  endtask

  task automatic recvQuad(input int n, input int startAddr);
    logic [3:0]  dv;
    logic [3:0]  ov;
    logic [31:0] word;
    bit          oeOk;
    sclkCycle(1'b0, dv, ov);
    check(ov == 4'b0000, "R4", "turnaround cycle enable", {28'b0, ov}, 32'h0);
    for (int w = 0; w < n; w++) begin
      word = '0;
      oeOk = 1'b1;
      for (int k = 0; k < 8; k++) begin
        sclkCycle(1'b0, dv, ov);
        word = {word[27:0], dv};
        if (ov != 4'b1111) oeOk = 1'b0;
      end
      check(word == memVal((startAddr + w) % DEPTH), (w == 0) ? "R4" : "R7",
            "quad word", word, memVal((startAddr + w) % DEPTH));
      check(oeOk, "R4", "quad enable pattern", {31'b0, oeOk}, 32'h1);
    end
  endtask

  initial begin
    logic [3:0] dv;
    logic [3:0] ov;
    logic [3:0] oeSeen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(dOe == 4'b0000, "R6", "reset output enable", {28'b0, dOe}, 32'h0);
    check(memRdEn == 1'b0, "R6", "reset read request", {31'b0, memRdEn}, 32'h0);

    // R3 R8: single-line read of three words from address 5
    selectDev();
    rdCount = 0;
    sendHeader(24'h000005, 8'h0B);
    recvSingle(3, 5);
    check(rdCount == 4, "R8", "reads for three words", rdCount, 32'd4);
    deselectDev();

    // R4 R7: quad read across the top of memory, upper address bits dropped
    selectDev();
    sendHeader(24'h1234FE, 8'h6B);
    recvQuad(4, 254);
    deselectDev();

    // R5: unknown command leaves every line undriven
    selectDev();
    sendHeader(24'h000010, 8'h03);
    oeSeen = '0;
    for (int i = 0; i < 40; i++) begin
      sclkCycle(1'b0, dv, ov);
      oeSeen |= ov;
    end
    check(oeSeen == 4'b0000, "R5", "drive after unknown command", {28'b0, oeSeen}, 32'h0);
    deselectDev();

    // R6: cancel in the middle of a data word, then a fresh quad read
    selectDev();
    sendHeader(24'h000020, 8'h0B);
    for (int i = 0; i < 10; i++) sclkCycle(1'b0, dv, ov);
    check(ov == 4'b0010, "R3", "driving before cancel", {28'b0, ov}, 32'h2);
    deselectDev();
    check(dOe == 4'b0000, "R6", "released after cancel", {28'b0, dOe}, 32'h0);
    selectDev();
    sendHeader(24'h000030, 8'h6B);
    recvQuad(2, 48);
    deselectDev();

    // R6: cancel in the middle of a header, then a fresh single read
    selectDev();
    for (int i = 0; i < 12; i++) sclkCycle(1'b1, dv, ov);
    deselectDev();
    selectDev();
    sendHeader(24'h000040, 8'h0B);
    recvSingle(1, 64);
    deselectDev();

    // R1: header bits each land in place (alternating address pattern)
    selectDev();
    sendHeader(24'hAAAA55, 8'h0B);
    recvSingle(2, 8'h55);
    deselectDev();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule